// File: doc/BRIEF.md
# Multi-lane coalescing request shift queue

This block buffers memory requests from several lanes in front of a coalescer. Each accepted enqueue writes one row across all lanes, with one slot per lane. A lane whose enqueue valid is low leaves its slot empty, so requests issued together stay aligned in the same row. Only the head row is visible at the dequeue side. Each lane drains its own head slot independently. The row as a whole moves forward once every slot in it has drained.

A downstream coalescer looks at the head row. It raises a lane's coalescable input to hold that lane's head entry back while it decides whether to merge it. If it claims entries, it drops them with the invalidate port, which takes a valid flag and a per-lane mask. Entries that are not held back are offered on the per-lane dequeue ports with a valid/ready handshake. Enqueue ready is shared by all lanes and depends only on how many rows are occupied.

Top module: `lane_coalesce_queue`

## Requirements
- R1: After reset the queue is empty: enqueue ready is high and every dequeue valid is low.
- R2: An accepted enqueue writes one row. Lane `l` takes its payload from bits `[l*DATA_W +: DATA_W]` of the enqueue data. Per lane, entries leave in the order they were enqueued.
- R3: Dequeue valid of a lane is high exactly when the head row holds a valid entry in that lane and that lane's coalescable input is low.
- R4: When every lane's coalescable input is high, no dequeue valid is asserted.
- R5: A head slot that completes a dequeue handshake reads as invalid from the next cycle. The other slots of the row keep their entries.
- R6: Once every slot of the head row is invalid, the row shifts out on the following clock edge. Under continuous full-row enqueue and dequeue, the head therefore alternates between offering a row and showing empty.
- R7: A slot left empty at enqueue time is never offered as valid, and dequeue ready on that lane has no effect.
- R8: Enqueue ready is low while all DEPTH rows are occupied. It rises only on the cycle after the head row has shifted out, with no look-ahead to a shift still pending.
- R9: An invalidate with its valid flag high clears the head slots selected by its mask (bit `l` selects lane `l`), without any dequeue handshake.
- R10: An enqueue cycle with every lane's enqueue valid low writes no row and consumes no capacity.
- R11: An enqueue presented while enqueue ready is low is dropped and never appears at the dequeue ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | LANES | Per-lane enqueue valid; bit l is lane l |
| enq_data | input | LANES*DATA_W | Per-lane enqueue payloads, lane l at [l*DATA_W +: DATA_W] |
| enq_ready | output | 1 | Shared enqueue ready, high while fewer than DEPTH rows are held |
| deq_valid | output | LANES | Per-lane dequeue valid from the head row |
| deq_data | output | LANES*DATA_W | Head-row payloads, lane l at [l*DATA_W +: DATA_W] |
| deq_ready | input | LANES | Per-lane dequeue ready |
| coalescable | input | LANES | Per-lane hold of the head entry for the coalescer |
| inv_valid | input | 1 | Invalidate request valid |
| inv_mask | input | LANES | Head slots to clear when inv_valid is high |

## Verification
The bench builds the block with 4 lanes, 4 rows and 8-bit payloads. With only four rows, a few single-cycle enqueues fill the queue, so the full condition and the single-cycle lag of ready after a shift come up repeatedly under random traffic. Four lanes allow partial rows and mixed coalescable patterns, and let the invalidate mask select lane subsets in every combination. A row-FIFO model predicts dequeue valid, payloads and enqueue ready every cycle, and directed sequences pin down the hold, drain, shift and drop corner cases.

// File: rtl/lcq_pkg.sv
// Package: shared sizing helpers for the lane coalescing queue.
// Assumes depths of at least one row.
package lcq_pkg;

    // Width of an index that addresses `n` rows (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that can hold the values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lcq_lane_column.sv
// Module: one lane's column of row slots, with row 0 as the head.
// On a shift every slot moves one row toward the head and the tail row
// empties. A write lands at the index supplied by the row controller, which
// already accounts for a shift on the same edge. The head clear is applied
// only when no shift happens on that edge.
// Assumes: the controller never writes a slot that is still holding an entry.
module lcq_lane_column #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                shift_i,
    input  logic                                wr_en_i,
    input  logic [lcq_pkg::idx_width(DEPTH)-1:0] wr_idx_i,
    input  logic                                wr_valid_i,
    input  logic [DATA_W-1:0]                   wr_data_i,
    input  logic                                head_clr_i,
    output logic                                head_valid_o,
    output logic [DATA_W-1:0]                   head_data_o
);
    localparam int unsigned IDX_W = lcq_pkg::idx_width(DEPTH);

    logic [DEPTH-1:0]  slot_v;
    logic [DATA_W-1:0] slot_d   [DEPTH];
    logic [DEPTH-1:0]  slot_v_nx;
    logic [DATA_W-1:0] slot_d_nx[DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic              up_v;
        logic [DATA_W-1:0] up_d;

        // Pick the neighbour that moves into this row on a shift.
        if (g < DEPTH - 1) begin : g_mid
            assign up_v = slot_v[g+1];
            assign up_d = slot_d[g+1];
        end else begin : g_tail
            assign up_v = 1'b0;
            assign up_d = slot_d[g];
        end

        // Next state of one slot: shift, head clear, then write.
        always_comb begin
            slot_v_nx[g] = shift_i ? up_v : slot_v[g];
            slot_d_nx[g] = shift_i ? up_d : slot_d[g];
            if (g == 0 && head_clr_i && !shift_i) begin
                slot_v_nx[g] = 1'b0;
            end
            if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                slot_v_nx[g] = wr_valid_i;
                slot_d_nx[g] = wr_data_i;
            end
        end

        // Payload register; it carries no reset because the valid bit guards it.
        always_ff @(posedge clk) begin
            slot_d[g] <= slot_d_nx[g];
        end
    end

    // Valid bits; a synchronous reset empties the column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v <= '0;
        end else begin
            slot_v <= slot_v_nx;
        end
    end

    assign head_valid_o = slot_v[0];
    assign head_data_o  = slot_d[0];

endmodule

// File: rtl/lcq_row_ctrl.sv
// Module: row occupancy control shared by all lanes.
// Counts the occupied rows, decides when the head row shifts out (the
// registered head slots are all empty), produces the shared enqueue ready
// from the count alone, and gives the write index that a new row takes
// after any shift on the same edge.
// Assumes: rows beyond the count hold no valid slots.
module lcq_row_ctrl #(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [LANES-1:0]                     head_valid_i,
    input  logic                                 any_enq_i,
    output logic                                 enq_ready_o,
    output logic                                 shift_o,
    output logic                                 wr_en_o,
    output logic [lcq_pkg::idx_width(DEPTH)-1:0] wr_idx_o
);
    localparam int unsigned IDX_W = lcq_pkg::idx_width(DEPTH);
    localparam int unsigned CNT_W = lcq_pkg::cnt_width(DEPTH);

    logic [CNT_W-1:0] rows_q;
    logic [CNT_W-1:0] rows_after_shift;

    // Shift, ready and write decisions for this cycle.
    always_comb begin
        shift_o          = (rows_q != '0) && (head_valid_i == '0);
        enq_ready_o      = rows_q < CNT_W'(DEPTH);
        wr_en_o          = enq_ready_o && any_enq_i;
        rows_after_shift = rows_q - CNT_W'(shift_o);
        wr_idx_o         = IDX_W'(rows_after_shift);
    end

    // Row occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q <= '0;
        end else begin
            rows_q <= rows_after_shift + CNT_W'(wr_en_o);
        end
    end

endmodule

// File: rtl/lcq_head_port.sv
// Module: dequeue side of the head row.
// Offers a lane's head entry only when the entry is valid and the lane is
// not held for coalescing, and turns dequeue handshakes and masked
// invalidates into per-lane head clear strobes.
// Assumes: head_valid_i is low for every lane while the queue is empty.
module lcq_head_port #(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES-1:0] head_valid_i,
    input  logic [LANES-1:0] coalescable_i,
    input  logic [LANES-1:0] deq_ready_i,
    input  logic             inv_valid_i,
    input  logic [LANES-1:0] inv_mask_i,
    output logic [LANES-1:0] deq_valid_o,
    output logic [LANES-1:0] head_clr_o
);
    logic [LANES-1:0] inv_sel;

    // Offered entries and the slots to clear on this edge.
    always_comb begin
        inv_sel     = inv_valid_i ? inv_mask_i : '0;
        deq_valid_o = head_valid_i & ~coalescable_i;
        head_clr_o  = (deq_valid_o & deq_ready_i) | (inv_sel & head_valid_i);
    end

endmodule

// File: rtl/lane_coalesce_queue.sv
// Module: multi-lane request shift queue in front of a coalescer.
// One row per enqueue, one slot per lane. Lanes drain their head slots on
// their own, and the row advances one edge after all its slots are empty.
// Assumes: enq_data / deq_data carry lane l at [l*DATA_W +: DATA_W].
module lane_coalesce_queue #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        enq_valid,
    input  logic [LANES*DATA_W-1:0] enq_data,
    output logic                    enq_ready,
    output logic [LANES-1:0]        deq_valid,
    output logic [LANES*DATA_W-1:0] deq_data,
    input  logic [LANES-1:0]        deq_ready,
    input  logic [LANES-1:0]        coalescable,
    input  logic                    inv_valid,
    input  logic [LANES-1:0]        inv_mask
);
    localparam int unsigned IDX_W = lcq_pkg::idx_width(DEPTH);

    logic [LANES-1:0] head_valid;
    logic [LANES-1:0] head_clr;
    logic             row_shift;
    logic             row_wr;
    logic [IDX_W-1:0] row_idx;
    logic             any_enq;

    assign any_enq = |enq_valid;

    lcq_row_ctrl #(
        .LANES (LANES),
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_valid_i (head_valid),
        .any_enq_i    (any_enq),
        .enq_ready_o  (enq_ready),
        .shift_o      (row_shift),
        .wr_en_o      (row_wr),
        .wr_idx_o     (row_idx)
    );

    lcq_head_port #(
        .LANES (LANES)
    ) u_head (
        .head_valid_i  (head_valid),
        .coalescable_i (coalescable),
        .deq_ready_i   (deq_ready),
        .inv_valid_i   (inv_valid),
        .inv_mask_i    (inv_mask),
        .deq_valid_o   (deq_valid),
        .head_clr_o    (head_clr)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lcq_lane_column #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W)
        ) u_col (
            .clk          (clk),
            .rst_n        (rst_n),
            .shift_i      (row_shift),
            .wr_en_i      (row_wr),
            .wr_idx_i     (row_idx),
            .wr_valid_i   (enq_valid[l]),
            .wr_data_i    (enq_data[l*DATA_W +: DATA_W]),
            .head_clr_i   (head_clr[l]),
            .head_valid_o (head_valid[l]),
            .head_data_o  (deq_data[l*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/lane_coalesce_queue_chk.sv
// Module: property checker for lane_coalesce_queue, attached by bind.
// Keeps its own row occupancy count from accepted enqueues and shifts and
// checks the port behaviour against it.
module lane_coalesce_queue_chk #(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] enq_valid,
    input logic             enq_ready,
    input logic [LANES-1:0] deq_valid,
    input logic [LANES-1:0] deq_ready,
    input logic [LANES-1:0] coalescable,
    input logic             inv_valid,
    input logic [LANES-1:0] inv_mask,
    input logic [LANES-1:0] head_valid,
    input logic             row_shift
);
    localparam int unsigned OCC_W = $clog2(DEPTH + 1) + 1;

    logic [OCC_W-1:0] occ;

    // Independent occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ + OCC_W'(enq_ready && (enq_valid != '0)) - OCC_W'(row_shift);
        end
    end

    // R8
    ready_tracks_occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_ready == (occ < OCC_W'(DEPTH)));

    // R4
    all_held_no_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&coalescable) |-> (deq_valid == '0));

    // R3
    held_lane_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid & coalescable) == '0);

    // R5
    drained_slot_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((deq_valid & deq_ready) != '0) |=> ((deq_valid & $past(deq_valid & deq_ready)) == '0));

    // R9
    invalidate_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && ((inv_mask & head_valid) != '0)) |=> ((head_valid & $past(inv_mask)) == '0));

    // R7
    empty_slot_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid & ~head_valid) == '0);

endmodule

bind lane_coalesce_queue lane_coalesce_queue_chk #(
    .LANES (LANES),
    .DEPTH (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid   (enq_valid),
    .enq_ready   (enq_ready),
    .deq_valid   (deq_valid),
    .deq_ready   (deq_ready),
    .coalescable (coalescable),
    .inv_valid   (inv_valid),
    .inv_mask    (inv_mask),
    .head_valid  (head_valid),
    .row_shift   (row_shift)
);

// File: tb/lane_coalesce_queue_test.sv
// Bench: row-FIFO scoreboard plus directed corner sequences.
module lane_coalesce_queue_test;
    localparam int unsigned L   = 4;
    localparam int unsigned D   = 4;
    localparam int unsigned W   = 8;
    localparam int unsigned CLK = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [L-1:0]   enq_valid = '0;
    logic [L*W-1:0] enq_data = '0;
    logic           enq_ready;
    logic [L-1:0]   deq_valid;
    logic [L*W-1:0] deq_data;
    logic [L-1:0]   deq_ready = '0;
    logic [L-1:0]   coalescable = '0;
    logic           inv_valid = 1'b0;
    logic [L-1:0]   inv_mask = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [L-1:0]   mdl_m[$];
    logic [L*W-1:0] mdl_d[$];

    lane_coalesce_queue #(.LANES(L), .DEPTH(D), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_data(enq_data),
        .enq_ready(enq_ready), .deq_valid(deq_valid), .deq_data(deq_data),
        .deq_ready(deq_ready), .coalescable(coalescable), .inv_valid(inv_valid),
        .inv_mask(inv_mask)
    );

    always #(CLK/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, then let combinational outputs settle.
    task automatic set_in(input logic [L-1:0] ev, input logic [L*W-1:0] ed, input logic [L-1:0] co,
                          input logic [L-1:0] dr, input logic iv, input logic [L-1:0] im);
        enq_valid = ev; enq_data = ed; coalescable = co;
        deq_ready = dr; inv_valid = iv; inv_mask = im;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor / scoreboard: compare against the row model, then advance it.
    always @(negedge clk) begin
        if (!rst_n) begin
            mdl_m.delete();
            mdl_d.delete();
        end else if (!done) begin
            logic         exp_rdy;
            logic [L-1:0] exp_dv;
            logic [L-1:0] fire;
            exp_rdy = (mdl_m.size() < D);
            exp_dv  = (mdl_m.size() > 0) ? (mdl_m[0] & ~coalescable) : '0;
            check(enq_ready == exp_rdy, "R8 scoreboard enq_ready", 64'(enq_ready), 64'(exp_rdy));
            check(deq_valid == exp_dv, "R3 scoreboard deq_valid", 64'(deq_valid), 64'(exp_dv));
            fire = exp_dv & deq_ready;
            for (int l = 0; l < L; l++) begin
                if (fire[l]) begin
                    check(deq_data[l*W +: W] == mdl_d[0][l*W +: W], "R2 scoreboard lane order",
                          64'(deq_data[l*W +: W]), 64'(mdl_d[0][l*W +: W]));
                end
            end
            if (mdl_m.size() > 0) begin
                if (mdl_m[0] == '0) begin
                    void'(mdl_m.pop_front());
                    void'(mdl_d.pop_front());
                end else begin
                    mdl_m[0] = mdl_m[0] & ~(fire | (inv_valid ? inv_mask : '0));
                end
            end
            if (exp_rdy && enq_valid != '0) begin
                mdl_m.push_back(enq_valid);
                mdl_d.push_back(enq_data);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        set_in('0, '0, '0, '0, 1'b0, '0);
        check(enq_ready == 1'b1, "R1 reset enq_ready", 64'(enq_ready), 64'h1);
        check(deq_valid == '0, "R1 reset deq_valid", 64'(deq_valid), 64'h0);

        // Three rows, the middle one partial, all lanes held.
        set_in(4'b1111, 32'h13121110, 4'b1111, '0, 1'b0, '0); tick();
        set_in(4'b0001, 32'h00000020, 4'b1111, '0, 1'b0, '0); tick();
        set_in(4'b1111, 32'h33323130, 4'b1111, '0, 1'b0, '0); tick();
        set_in('0, '0, 4'b1111, 4'b1111, 1'b0, '0);
        check(deq_valid == '0, "R4 all held", 64'(deq_valid), 64'h0);
        tick();
        set_in('0, '0, 4'b1000, 4'b1001, 1'b0, '0);
        check(deq_valid == 4'b0111, "R3 partial hold", 64'(deq_valid), 64'h7);
        check(deq_data[7:0] == 8'h10, "R2 head lane0", 64'(deq_data[7:0]), 64'h10);
        tick();
        set_in('0, '0, '0, '0, 1'b0, '0);
        check(deq_valid == 4'b1110, "R5 drained slot only", 64'(deq_valid), 64'he);
        tick();
        set_in('0, '0, '0, 4'b1111, 1'b0, '0);
        tick();
        check(deq_valid == '0, "R6 empty head before shift", 64'(deq_valid), 64'h0);
        tick();
        check(deq_valid == 4'b0001, "R7 partial row offers lane0 only", 64'(deq_valid), 64'h1);
        check(deq_data[7:0] == 8'h20, "R2 second row lane0", 64'(deq_data[7:0]), 64'h20);
        tick();
        check(deq_valid == '0, "R7 empty lanes ignore ready", 64'(deq_valid), 64'h0);
        tick();
        set_in('0, '0, '0, '0, 1'b1, 4'b0101);
        check(deq_valid == 4'b1111, "R2 third row offered", 64'(deq_valid), 64'hf);
        tick();
        set_in('0, '0, '0, '0, 1'b0, '0);
        check(deq_valid == 4'b1010, "R9 invalidate cleared mask", 64'(deq_valid), 64'ha);
        set_in('0, '0, '0, 4'b1111, 1'b0, '0);
        tick(); tick(); tick();
        check(deq_valid == '0, "R6 drained to empty", 64'(deq_valid), 64'h0);

        // Fill: 3 rows, an all-invalid cycle, then the 4th row.
        for (int r = 0; r < 3; r++) begin
            set_in(4'b1111, {4{8'(8'h50 + 8'(r))}} + 32'h03020100, '0, '0, 1'b0, '0); tick();
        end
        set_in('0, 32'hdeadbeef, '0, '0, 1'b0, '0); tick();
        check(enq_ready == 1'b1, "R10 empty enqueue took no row", 64'(enq_ready), 64'h1);
        set_in(4'b1111, 32'h63626160, '0, '0, 1'b0, '0); tick();
        check(enq_ready == 1'b0, "R8 full", 64'(enq_ready), 64'h0);
        set_in(4'b1111, 32'hEEEEEEEE, '0, '0, 1'b0, '0); tick();
        set_in('0, '0, '0, 4'b1111, 1'b0, '0);
        check(deq_valid == 4'b1111, "R8 head offered while full", 64'(deq_valid), 64'hf);
        tick();
        check(enq_ready == 1'b0, "R8 no look-ahead to pending shift", 64'(enq_ready), 64'h0);
        tick();
        check(enq_ready == 1'b1, "R8 ready after shift", 64'(enq_ready), 64'h1);
        repeat (8) tick();
        check(deq_valid == '0, "R11 dropped row never appears", 64'(deq_valid), 64'h0);

        // Continuous full rows with all lanes draining.
        set_in(4'b1111, 32'h71727374, '0, 4'b1111, 1'b0, '0); tick();
        for (int k = 1; k <= 6; k++) begin
            check(deq_valid == ((k % 2 == 1) ? 4'b1111 : 4'b0000), "R6 alternating head",
                  64'(deq_valid), (k % 2 == 1) ? 64'hf : 64'h0);
            enq_data = enq_data + 32'h01010101;
            tick();
        end
        set_in('0, '0, '0, 4'b1111, 1'b0, '0);
        repeat (10) tick();

        // Random traffic checked by the scoreboard.
        for (int c = 0; c < 600; c++) begin
            set_in(L'($urandom), ($urandom), L'($urandom & $urandom), L'($urandom | $urandom),
                   ($urandom % 8) == 0, L'($urandom));
            tick();
        end
        set_in('0, '0, '0, 4'b1111, 1'b0, '0);
        repeat (2 * D + 4) tick();
        check(deq_valid == '0, "R6 final drain deq_valid", 64'(deq_valid), 64'h0);
        check(enq_ready == 1'b1, "R8 final drain enq_ready", 64'(enq_ready), 64'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule